// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Vector Arbiter

This block keeps the receive and transmit interrupt state of a two-channel serial controller. For each channel it tracks four things: whether a received character is waiting, whether a transmit interrupt is pending, and whether either of them is currently under service. From this state it builds three outputs: a single registered interrupt request, a six-bit pending register and an eight-bit vector register. The vector code reports which source raised or cleared the most recent event.

A channel changes state on four kinds of stimulus: line events (a receive byte arriving, the transmitter going empty), host strobes on the data port (read or write), and two command strobes (reset the highest under-service level, clear the transmit interrupt). A status mode bit selects where the three-bit vector code sits in the vector byte. Channel index 0 is channel B and index 1 is channel A in every packed per-channel port.

Top module: `sio_irq_arbiter`

## Requirements
- R1: An accepted receive byte on a channel sets its receive-available and receive-under-service state and its receive pending bit (A: bit 5, B: bit 2). It also loads the receive vector code for that channel.
- R2: A transmit-empty event or a host data write sets transmit pending. Transmit under-service, the pending bit and the vector update follow only if no receive is under service on that channel; otherwise the vector and pending register stay unchanged.
- R3: A reset-under-service command clears receive under-service if it is set, and then re-raises a still-pending transmit interrupt (vector code and pending bit). Otherwise it clears transmit under-service.
- R4: The vector byte holds a 3-bit code. With cfg_stat_hi low the code sits in bits 3:1 and is none=011, receive A=110, receive B=010, transmit A=100, transmit B=000. With cfg_stat_hi high the code sits bit-reversed in bits 6:4, giving bytes 0x60, 0x30, 0x20, 0x10 and 0x00. All other bits read 0.
- R5: The transmit pending bits (A: bit 4, B: bit 1) are set only when that channel's transmit interrupt enable is high. Bits 0 and 3 always read 0.
- R6: irq goes high one cycle after the state satisfies one of these on either channel: transmit enable with transmit pending; receive mode 01 or 10 with receive available; break enable with break status high.
- R7: A clear-transmit command clears transmit pending, transmit under-service and the transmit pending bit, and loads the none code. If a received byte is still available, it then re-raises the receive interrupt with the receive code.
- R8: A host data read clears receive available, receive under-service and the receive pending bit, and loads the none code. If transmit is still pending, it then re-raises the transmit interrupt.
- R9: A receive byte is accepted only when receive is enabled and no unread byte is waiting; otherwise it changes nothing.
- R10: When both channels update the vector in the same cycle, channel A's code is stored.
- R11: Within one channel, coincident strobes act by priority: host read first, then host write or transmit-empty, then reset-under-service, then clear-transmit, then receive byte. Lower-ranked strobes are dropped.
- R12: After reset, irq, the pending register, the vector byte and receive available all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_evt | input | 2 | Receive byte arrived, per channel |
| txe_evt | input | 2 | Transmitter went empty, per channel |
| host_wr | input | 2 | Host wrote the data port, per channel |
| host_rd | input | 2 | Host read the data port, per channel |
| cmd_rst_ius | input | 2 | Reset-highest-under-service command strobe |
| cmd_clr_tx | input | 2 | Clear-transmit-interrupt command strobe |
| cfg_rx_en | input | 2 | Receive enable |
| cfg_tx_ie | input | 2 | Transmit interrupt enable |
| cfg_rx_mode | input | 4 | Receive interrupt mode, 2 bits per channel (B in 1:0) |
| cfg_brk_ie | input | 2 | Break interrupt enable |
| brk_stat | input | 2 | Break status level |
| cfg_stat_hi | input | 1 | Vector code placement select |
| irq | output | 1 | Combined interrupt request |
| ipend | output | 6 | Interrupt pending register |
| ivec | output | 8 | Modified vector register |
| rx_avail | output | 2 | Received byte waiting, per channel |

## Verification
Some invariants are checked by the assertions on every cycle:
- receive under-service never exists without a waiting byte;
- transmit under-service never rises while a receive is under service;
- a data read always empties the receive side;
- a transmit pending bit rises only with its enable;
- a refused receive byte leaves the channel untouched;
- irq is never raised without a cause in the previous cycle.

Other behaviour is shown only by the bench's scenarios:
- the exact vector bytes in both placement modes;
- the re-arming chains after reset-under-service, clear-transmit and data read;
- channel A winning a vector collision;
- per-channel strobe priority;
- the gating of irq by receive mode and break enable.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
   localparam int VCODE_W = 3;
   localparam int RXM_W   = 2;
   localparam int CH_B    = 0;
   localparam int CH_A    = 1;

   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_RX   = 2'd1,
      K_TX   = 2'd2
   } vkind_e;

   // low-placement codes; high placement is the bit reversal
   localparam logic [VCODE_W-1:0] LC_NONE = 3'b011;
   localparam logic [VCODE_W-1:0] LC_RX_A = 3'b110;
   localparam logic [VCODE_W-1:0] LC_RX_B = 3'b010;
   localparam logic [VCODE_W-1:0] LC_TX_A = 3'b100;
   localparam logic [VCODE_W-1:0] LC_TX_B = 3'b000;

   function automatic logic [VCODE_W-1:0] low_code(input logic is_a, input vkind_e k);
      case (k)
         K_RX:    low_code = is_a ? LC_RX_A : LC_RX_B;
         K_TX:    low_code = is_a ? LC_TX_A : LC_TX_B;
         default: low_code = LC_NONE;
      endcase
   endfunction

   function automatic logic [VCODE_W-1:0] rev_code(input logic [VCODE_W-1:0] c);
      for (int i = 0; i < VCODE_W; i++) rev_code[i] = c[VCODE_W-1-i];
   endfunction
endpackage

// File: rtl/sio_irq_chan.sv
module sio_irq_chan
   import sio_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_evt,
   input  logic             txe_evt,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic             cmd_rst_ius,
   input  logic             cmd_clr_tx,
   input  logic             rx_en,
   input  logic             tx_ie,
   input  logic [RXM_W-1:0] rx_mode,
   input  logic             brk_ie,
   input  logic             brk_stat,
   output logic             rx_avail,
   output logic             tx_pend,
   output logic             ip_tx,
   output logic             req,
   output logic             vec_upd,
   output vkind_e           vec_kind
);
   logic rx_ius, tx_ius;
   logic n_av, n_rxius, n_txp, n_txius, n_iptx;

   always_comb begin
      n_av     = rx_avail;
      n_rxius  = rx_ius;
      n_txp    = tx_pend;
      n_txius  = tx_ius;
      n_iptx   = ip_tx;
      vec_upd  = 1'b0;
      vec_kind = K_NONE;
      if (host_rd) begin
         n_av    = 1'b0;
         n_rxius = 1'b0;
         vec_upd = 1'b1;
         if (tx_pend) begin
            n_txius  = 1'b1;
            n_iptx   = ip_tx | tx_ie;
            vec_kind = K_TX;
         end
      end else if (host_wr || txe_evt) begin
         n_txp = 1'b1;
         if (!rx_ius) begin
            n_txius  = 1'b1;
            n_iptx   = ip_tx | tx_ie;
            vec_upd  = 1'b1;
            vec_kind = K_TX;
         end
      end else if (cmd_rst_ius) begin
         if (rx_ius) begin
            n_rxius = 1'b0;
            if (tx_pend) begin
               n_txius  = 1'b1;
               n_iptx   = ip_tx | tx_ie;
               vec_upd  = 1'b1;
               vec_kind = K_TX;
            end
         end else begin
            n_txius = 1'b0;
         end
      end else if (cmd_clr_tx) begin
         n_txp   = 1'b0;
         n_txius = 1'b0;
         n_iptx  = 1'b0;
         vec_upd = 1'b1;
         if (rx_avail) begin
            n_rxius  = 1'b1;
            vec_kind = K_RX;
         end
      end else if (rx_evt && rx_en && !rx_avail) begin
         n_av     = 1'b1;
         n_rxius  = 1'b1;
         vec_upd  = 1'b1;
         vec_kind = K_RX;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_avail <= 1'b0;
         rx_ius   <= 1'b0;
         tx_pend  <= 1'b0;
         tx_ius   <= 1'b0;
         ip_tx    <= 1'b0;
      end else begin
         rx_avail <= n_av;
         rx_ius   <= n_rxius;
         tx_pend  <= n_txp;
         tx_ius   <= n_txius;
         ip_tx    <= n_iptx;
      end
   end

   assign req = (tx_ie & tx_pend)
              | (((rx_mode == 2'b01) || (rx_mode == 2'b10)) & rx_avail)
              | (brk_ie & brk_stat);

   p_rxius_avail_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ius |-> rx_avail);
   p_txius_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ius) |-> !rx_ius);
   p_iptx_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ip_tx) |-> $past(tx_ie));
   p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd |=> (!rx_avail && !rx_ius));
   p_rx_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt && !rx_en && !host_rd && !host_wr && !txe_evt && !cmd_rst_ius && !cmd_clr_tx)
      |=> $stable(rx_avail));
endmodule

// File: rtl/sio_vec_sel.sv
module sio_vec_sel
   import sio_irq_pkg::*;
#(
   parameter int CH_N  = 2,
   parameter int VEC_W = 8
) (
   input  logic [CH_N-1:0]         upd,
   input  vkind_e [CH_N-1:0]       kind,
   input  logic                    stat_hi,
   output logic                    load,
   output logic [VEC_W-1:0]        vec
);
   logic             sel_a;
   logic [VCODE_W-1:0] code;

   assign sel_a = upd[CH_A];
   assign load  = |upd;
   assign code  = low_code(sel_a, sel_a ? kind[CH_A] : kind[CH_B]);

   always_comb begin
      vec = '0;
      if (stat_hi) vec[6:4] = rev_code(code);
      else         vec[3:1] = code;
   end
endmodule

// File: rtl/sio_irq_arbiter.sv
module sio_irq_arbiter
   import sio_irq_pkg::*;
#(
   parameter int CH_N    = 2,
   parameter int VEC_W   = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CH_N-1:0]       rx_evt,
   input  logic [CH_N-1:0]       txe_evt,
   input  logic [CH_N-1:0]       host_wr,
   input  logic [CH_N-1:0]       host_rd,
   input  logic [CH_N-1:0]       cmd_rst_ius,
   input  logic [CH_N-1:0]       cmd_clr_tx,
   input  logic [CH_N-1:0]       cfg_rx_en,
   input  logic [CH_N-1:0]       cfg_tx_ie,
   input  logic [CH_N*2-1:0]     cfg_rx_mode,
   input  logic [CH_N-1:0]       cfg_brk_ie,
   input  logic [CH_N-1:0]       brk_stat,
   input  logic                  cfg_stat_hi,
   output logic                  irq,
   output logic [CH_N*3-1:0]     ipend,
   output logic [VEC_W-1:0]      ivec,
   output logic [CH_N-1:0]       rx_avail
);
   localparam int IP_PER_CH = 3;

   if (CH_N != 2) begin : g_bad_ch
      $error("sio_irq_arbiter: CH_N must be 2");
   end
   if (VEC_W < 7) begin : g_bad_vec
      $error("sio_irq_arbiter: VEC_W must be at least 7");
   end

   logic [CH_N-1:0] tx_pend, ip_tx, req, vec_upd;
   vkind_e [CH_N-1:0] vec_kind;
   logic              vec_load;
   logic [VEC_W-1:0]  vec_nxt;
   logic [VEC_W-1:0]  ivec_q;

   for (genvar c = 0; c < CH_N; c++) begin : g_ch
      sio_irq_chan i_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .rx_evt      (rx_evt[c]),
         .txe_evt     (txe_evt[c]),
         .host_wr     (host_wr[c]),
         .host_rd     (host_rd[c]),
         .cmd_rst_ius (cmd_rst_ius[c]),
         .cmd_clr_tx  (cmd_clr_tx[c]),
         .rx_en       (cfg_rx_en[c]),
         .tx_ie       (cfg_tx_ie[c]),
         .rx_mode     (cfg_rx_mode[c*RXM_W +: RXM_W]),
         .brk_ie      (cfg_brk_ie[c]),
         .brk_stat    (brk_stat[c]),
         .rx_avail    (rx_avail[c]),
         .tx_pend     (tx_pend[c]),
         .ip_tx       (ip_tx[c]),
         .req         (req[c]),
         .vec_upd     (vec_upd[c]),
         .vec_kind    (vec_kind[c])
      );
      assign ipend[c*IP_PER_CH + 0] = 1'b0;
      assign ipend[c*IP_PER_CH + 1] = ip_tx[c];
      assign ipend[c*IP_PER_CH + 2] = rx_avail[c];
   end

   sio_vec_sel #(.CH_N(CH_N), .VEC_W(VEC_W)) i_vsel (
      .upd     (vec_upd),
      .kind    (vec_kind),
      .stat_hi (cfg_stat_hi),
      .load    (vec_load),
      .vec     (vec_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        ivec_q <= '0;
      else if (vec_load) ivec_q <= vec_nxt;
   end
   assign ivec = ivec_q;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |req;
      end
      assign irq = irq_q;

      p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> $past(|(tx_pend | rx_avail | brk_stat)));
   end else begin : g_irq_comb
      assign irq = |req;
   end
endmodule

// File: tb/test_sio_irq_arbiter.sv
module test_sio_irq_arbiter;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [1:0] rx_evt = '0, txe_evt = '0, host_wr = '0, host_rd = '0;
   logic [1:0] cmd_rst_ius = '0, cmd_clr_tx = '0;
   logic [1:0] cfg_rx_en = 2'b11, cfg_tx_ie = 2'b11;
   logic [3:0] cfg_rx_mode = 4'b0101;
   logic [1:0] cfg_brk_ie = '0, brk_stat = '0;
   logic       cfg_stat_hi = 1'b0;
   logic       irq;
   logic [5:0] ipend;
   logic [7:0] ivec;
   logic [1:0] rx_avail;

   sio_irq_arbiter i_sio_irq_arbiter (
      .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .txe_evt(txe_evt),
      .host_wr(host_wr), .host_rd(host_rd), .cmd_rst_ius(cmd_rst_ius),
      .cmd_clr_tx(cmd_clr_tx), .cfg_rx_en(cfg_rx_en), .cfg_tx_ie(cfg_tx_ie),
      .cfg_rx_mode(cfg_rx_mode), .cfg_brk_ie(cfg_brk_ie), .brk_stat(brk_stat),
      .cfg_stat_hi(cfg_stat_hi), .irq(irq), .ipend(ipend), .ivec(ivec),
      .rx_avail(rx_avail)
   );

   typedef struct {
      string      tag;
      logic [5:0] ip;
      logic [7:0] vec;
      logic [1:0] av;
      logic       irq;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic cmp(input string tag, input string fld, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
      end
   endtask

   // monitor: samples mid-high phase, away from both edges
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "ipend", ipend, e.ip);
            cmp(e.tag, "ivec", ivec, e.vec);
            cmp(e.tag, "rx_avail", rx_avail, e.av);
            cmp(e.tag, "irq", irq, e.irq);
         end
      end
   end

   // driver: strobe bits are {A,B}
   task automatic step(input string tag,
                       input logic [1:0] rx, input logic [1:0] txe, input logic [1:0] wr,
                       input logic [1:0] rd, input logic [1:0] rius, input logic [1:0] ctx,
                       input logic [5:0] eip, input logic [7:0] evec,
                       input logic [1:0] eav, input logic eirq);
      exp_t e;
      @(negedge clk);
      rx_evt = rx; txe_evt = txe; host_wr = wr; host_rd = rd;
      cmd_rst_ius = rius; cmd_clr_tx = ctx;
      @(negedge clk);
      rx_evt = '0; txe_evt = '0; host_wr = '0; host_rd = '0;
      cmd_rst_ius = '0; cmd_clr_tx = '0;
      @(negedge clk);
      e.tag = tag; e.ip = eip; e.vec = evec; e.av = eav; e.irq = eirq;
      q.push_back(e);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R12 actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      //          tag                    rx    txe   wr    rd    rius  ctx   ip     vec    av    irq
      step("R12 reset state",           2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,6'h00,8'h00,2'b00,1'b0);
      step("R1 rx A low",               2'b10,2'b00,2'b00,2'b00,2'b00,2'b00,6'h20,8'h0C,2'b10,1'b1);
      step("R2 txe A blocked",          2'b00,2'b10,2'b00,2'b00,2'b00,2'b00,6'h20,8'h0C,2'b10,1'b1);
      step("R3 rst ius rearms tx",      2'b00,2'b00,2'b00,2'b00,2'b10,2'b00,6'h30,8'h08,2'b10,1'b1);
      step("R8 read A rearms tx",       2'b00,2'b00,2'b00,2'b10,2'b00,2'b00,6'h10,8'h08,2'b00,1'b1);
      step("R7 clr tx A",               2'b00,2'b00,2'b00,2'b00,2'b00,2'b10,6'h00,8'h06,2'b00,1'b0);
      step("R2 write B unblocked",      2'b00,2'b00,2'b01,2'b00,2'b00,2'b00,6'h02,8'h00,2'b00,1'b1);
      step("R1 rx B low",               2'b01,2'b00,2'b00,2'b00,2'b00,2'b00,6'h06,8'h04,2'b01,1'b1);
      step("R7 clr tx B rearms rx",     2'b00,2'b00,2'b00,2'b00,2'b00,2'b01,6'h04,8'h04,2'b01,1'b1);
      cfg_stat_hi = 1'b1;
      step("R4 read B none high",       2'b00,2'b00,2'b00,2'b01,2'b00,2'b00,6'h00,8'h60,2'b00,1'b0);
      step("R4 rx A high",              2'b10,2'b00,2'b00,2'b00,2'b00,2'b00,6'h20,8'h30,2'b10,1'b1);
      step("R4 rx B high",              2'b01,2'b00,2'b00,2'b00,2'b00,2'b00,6'h24,8'h20,2'b11,1'b1);
      step("R2 txe A blocked high",     2'b00,2'b10,2'b00,2'b00,2'b00,2'b00,6'h24,8'h20,2'b11,1'b1);
      step("R4 R8 read A tx A high",    2'b00,2'b00,2'b00,2'b10,2'b00,2'b00,6'h14,8'h10,2'b01,1'b1);
      step("R10 both read A wins",      2'b00,2'b00,2'b00,2'b11,2'b00,2'b00,6'h10,8'h10,2'b00,1'b1);
      step("R7 clr tx A high",          2'b00,2'b00,2'b00,2'b00,2'b00,2'b10,6'h00,8'h60,2'b00,1'b0);
      step("R4 tx B high is zero",      2'b00,2'b00,2'b01,2'b00,2'b00,2'b00,6'h02,8'h00,2'b00,1'b1);
      step("R7 clr tx B high",          2'b00,2'b00,2'b00,2'b00,2'b00,2'b01,6'h00,8'h60,2'b00,1'b0);
      cfg_tx_ie = 2'b01;
      step("R5 txe A no enable",        2'b00,2'b10,2'b00,2'b00,2'b00,2'b00,6'h00,8'h10,2'b00,1'b0);
      step("R5 clr tx A",               2'b00,2'b00,2'b00,2'b00,2'b00,2'b10,6'h00,8'h60,2'b00,1'b0);
      cfg_tx_ie = 2'b11;
      cfg_rx_en = 2'b01;
      step("R9 rx A disabled",          2'b10,2'b00,2'b00,2'b00,2'b00,2'b00,6'h00,8'h60,2'b00,1'b0);
      cfg_rx_en = 2'b11;
      step("R9 rx B",                   2'b01,2'b00,2'b00,2'b00,2'b00,2'b00,6'h04,8'h20,2'b01,1'b1);
      step("R9 rx A",                   2'b10,2'b00,2'b00,2'b00,2'b00,2'b00,6'h24,8'h30,2'b11,1'b1);
      step("R9 rx B while unread",      2'b01,2'b00,2'b00,2'b00,2'b00,2'b00,6'h24,8'h30,2'b11,1'b1);
      cfg_rx_mode = 4'b0000;
      step("R6 rx mode 00 quiet",       2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,6'h24,8'h30,2'b11,1'b0);
      cfg_rx_mode = 4'b1100;
      step("R6 rx mode 11 quiet",       2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,6'h24,8'h30,2'b11,1'b0);
      cfg_rx_mode = 4'b1000;
      step("R6 rx mode 10 raises",      2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,6'h24,8'h30,2'b11,1'b1);
      cfg_rx_mode = 4'b0000;
      brk_stat = 2'b01;
      step("R6 break not enabled",      2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,6'h24,8'h30,2'b11,1'b0);
      cfg_brk_ie = 2'b01;
      step("R6 break enabled",          2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,6'h24,8'h30,2'b11,1'b1);
      cfg_brk_ie = 2'b00;
      brk_stat = 2'b00;
      cfg_rx_mode = 4'b0101;
      step("R8 read both",              2'b00,2'b00,2'b00,2'b11,2'b00,2'b00,6'h00,8'h60,2'b00,1'b0);
      step("R11 txe beats rx",          2'b10,2'b10,2'b00,2'b00,2'b00,2'b00,6'h10,8'h10,2'b00,1'b1);
      step("R11 clr beats rx",          2'b10,2'b00,2'b00,2'b00,2'b00,2'b10,6'h00,8'h60,2'b00,1'b0);
      repeat (4) @(negedge clk);
      done = 1'b1;
      summary();
   end
endmodule